// File: doc/BRIEF.md
# Request-Grant Bus Protocol Checker

This block watches the control strobes of a simple single-master bus and flags protocol violations. A transaction runs as a fixed pipeline with one cycle per phase: a one-cycle bus request, a grant in the next cycle, a read or write command in the cycle after that, and then, one cycle after the command, the address-valid flag together with the matching data-valid flag. The bus also carries an 8-bit address and two 64-bit data buses. Their values are not checked, so they are not ports of this block.

Each rule has its own sticky error output. Once an error output goes high it stays high until reset. This lets a simulation harness or an on-chip debug path tell at a glance which rule was broken. The first sampled cycle after reset has no previous cycle to compare against, so every check is masked in that cycle.

Top module: `bus_proto_monitor`

## Requirements
- R1: If bus request is high in two consecutive sampled cycles, `err_req_width` is set.
- R2: If bus request was high in the previous cycle and grant is low in the current cycle, `err_gnt_missing` is set.
- R3: If bus request was low in the previous cycle and grant is high in the current cycle, `err_gnt_spurious` is set.
- R4: If a read or write command is high and grant was low in the previous cycle, `err_cmd_ungranted` is set.
- R5: If read and write are high in the same cycle, `err_cmd_clash` is set.
- R6: If address-valid differs from "a read or write was high in the previous cycle", `err_addr_phase` is set.
- R7: If read-data-valid differs from the previous cycle's read command, `err_rdata_phase` is set.
- R8: If write-data-valid differs from the previous cycle's write command, `err_wdata_phase` is set.
- R9: Every error output is sticky: once high, it stays high until reset, whatever the bus does afterwards.
- R10: In the first sampled cycle after reset, no check is applied, so no error output can rise at that clock edge.
- R11: While reset is asserted, and directly after it, all error outputs are low.
- R12: An error output rises at the clock edge that samples the violating cycle. It is visible in that same clock period, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request pulse from the master |
| bus_gnt | input | 1 | Grant returned to the master |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| addr_ok | input | 1 | Address-valid flag |
| rdata_ok | input | 1 | Read-data-valid flag |
| wdata_ok | input | 1 | Write-data-valid flag |
| err_req_width | output | 1 | Sticky: request held for more than one cycle |
| err_gnt_missing | output | 1 | Sticky: no grant after a request |
| err_gnt_spurious | output | 1 | Sticky: grant without a preceding request |
| err_cmd_ungranted | output | 1 | Sticky: command not directly after a grant |
| err_cmd_clash | output | 1 | Sticky: read and write in the same cycle |
| err_addr_phase | output | 1 | Sticky: address-valid out of phase with the commands |
| err_rdata_phase | output | 1 | Sticky: read-data-valid out of phase with reads |
| err_wdata_phase | output | 1 | Sticky: write-data-valid out of phase with writes |

## Verification
Each rule compares the current cycle with the one before it. A violation is therefore judged at the rising edge that samples its second cycle, and the flag is set by that same edge. The bench drives every cycle on a falling edge and steps its model of the expected flags right after the following rising edge. It then compares all eight outputs on the next falling edge, which puts every result exactly one register behind its stimulus. Directed cases cover each rule, the masked first cycle after reset and flags that must persist through later legal traffic. Seeded random legal traffic with occasional single-signal corruption covers overlapping transactions.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;

   localparam int NUM_RULES = 8;

   localparam int RULE_REQ_WIDTH   = 0;
   localparam int RULE_GNT_MISSING = 1;
   localparam int RULE_GNT_SPUR    = 2;
   localparam int RULE_CMD_NOGNT   = 3;
   localparam int RULE_CMD_CLASH   = 4;
   localparam int RULE_ADDR_PHASE  = 5;
   localparam int RULE_RDATA_PHASE = 6;
   localparam int RULE_WDATA_PHASE = 7;

   typedef struct packed {
      logic req;
      logic gnt;
      logic rd;
      logic wr;
      logic avld;
      logic rvld;
      logic wvld;
   } bus_sample_t;

   typedef struct packed {
      logic req;
      logic gnt;
      logic rd;
      logic wr;
   } bus_hist_t;

endpackage

// File: rtl/bus_mon_history.sv
module bus_mon_history
   import bus_mon_pkg::*;
#(
   parameter int SETTLE_CYCLES = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  bus_hist_t cur,
   output bus_hist_t prev,
   output logic      armed
);

   localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("bus_mon_history: SETTLE_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
      end else begin
         prev <= cur;
      end
   end

   if (SETTLE_CYCLES == 1) begin : g_flag
      logic armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b0;
         end else begin
            armed_q <= 1'b1;
         end
      end
      assign armed = armed_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (cnt_q != CNT_W'(SETTLE_CYCLES)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
      assign armed = (cnt_q == CNT_W'(SETTLE_CYCLES));
   end

endmodule

// File: rtl/bus_mon_rules.sv
module bus_mon_rules
   import bus_mon_pkg::*;
(
   input  bus_sample_t          cur,
   input  bus_hist_t            prev,
   output logic [NUM_RULES-1:0] viol
);

   logic cmd_now;
   logic cmd_before;

   assign cmd_now    = cur.rd | cur.wr;
   assign cmd_before = prev.rd | prev.wr;

   always_comb begin
      viol                   = '0;
      viol[RULE_REQ_WIDTH]   = cur.req & prev.req;
      viol[RULE_GNT_MISSING] = prev.req & ~cur.gnt;
      viol[RULE_GNT_SPUR]    = ~prev.req & cur.gnt;
      viol[RULE_CMD_NOGNT]   = cmd_now & ~prev.gnt;
      viol[RULE_CMD_CLASH]   = cur.rd & cur.wr;
      viol[RULE_ADDR_PHASE]  = cur.avld ^ cmd_before;
      viol[RULE_RDATA_PHASE] = cur.rvld ^ prev.rd;
      viol[RULE_WDATA_PHASE] = cur.wvld ^ prev.wr;
   end

endmodule

// File: rtl/bus_mon_sticky.sv
module bus_mon_sticky #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic [N-1:0] hit,
   output logic [N-1:0] flags
);

   if (N < 1) begin : g_bad_n
      $error("bus_mon_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
         end else if (enable && hit[i]) begin
            flags[i] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bus_proto_monitor.sv
module bus_proto_monitor
   import bus_mon_pkg::*;
#(
   parameter int SETTLE_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req,
   input  logic bus_gnt,
   input  logic cmd_rd,
   input  logic cmd_wr,
   input  logic addr_ok,
   input  logic rdata_ok,
   input  logic wdata_ok,
   output logic err_req_width,
   output logic err_gnt_missing,
   output logic err_gnt_spurious,
   output logic err_cmd_ungranted,
   output logic err_cmd_clash,
   output logic err_addr_phase,
   output logic err_rdata_phase,
   output logic err_wdata_phase
);

   bus_sample_t          sample;
   bus_hist_t            hist_cur;
   bus_hist_t            hist_prev;
   logic                 checks_on;
   logic [NUM_RULES-1:0] rule_hit;
   logic [NUM_RULES-1:0] err_flags;

   assign sample = '{req: bus_req, gnt: bus_gnt, rd: cmd_rd, wr: cmd_wr,
                     avld: addr_ok, rvld: rdata_ok, wvld: wdata_ok};
   assign hist_cur = '{req: bus_req, gnt: bus_gnt, rd: cmd_rd, wr: cmd_wr};

   bus_mon_history #(
      .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (hist_cur),
      .prev  (hist_prev),
      .armed (checks_on)
   );

   bus_mon_rules u_rules (
      .cur  (sample),
      .prev (hist_prev),
      .viol (rule_hit)
   );

   bus_mon_sticky #(
      .N(NUM_RULES)
   ) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (checks_on),
      .hit    (rule_hit),
      .flags  (err_flags)
   );

   assign err_req_width     = err_flags[RULE_REQ_WIDTH];
   assign err_gnt_missing   = err_flags[RULE_GNT_MISSING];
   assign err_gnt_spurious  = err_flags[RULE_GNT_SPUR];
   assign err_cmd_ungranted = err_flags[RULE_CMD_NOGNT];
   assign err_cmd_clash     = err_flags[RULE_CMD_CLASH];
   assign err_addr_phase    = err_flags[RULE_ADDR_PHASE];
   assign err_rdata_phase   = err_flags[RULE_RDATA_PHASE];
   assign err_wdata_phase   = err_flags[RULE_WDATA_PHASE];

endmodule

// File: rtl/bus_mon_checker.sv
module bus_mon_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_req,
   input logic       bus_gnt,
   input logic       cmd_rd,
   input logic       cmd_wr,
   input logic       rdata_ok,
   input logic       armed,
   input logic [7:0] errs
);

   assert_req_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && bus_req && $past(bus_req)) |=> errs[0]);

   assert_gnt_missing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(bus_req) && !bus_gnt) |=> errs[1]);

   assert_gnt_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(bus_req) && bus_gnt) |=> errs[2]);

   assert_cmd_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cmd_rd && cmd_wr) |=> errs[4]);

   assert_rdata_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (rdata_ok != $past(cmd_rd))) |=> errs[6]);

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((errs & $past(errs)) == $past(errs)));

   assert_first_cycle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> $stable(errs));

endmodule

bind bus_proto_monitor bus_mon_checker u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .cmd_rd   (cmd_rd),
   .cmd_wr   (cmd_wr),
   .rdata_ok (rdata_ok),
   .armed    (checks_on),
   .errs     (err_flags)
);

// File: tb/bus_proto_monitor_test.sv
`timescale 1ns/1ps
module bus_proto_monitor_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic b = 0, g = 0, r = 0, w = 0, a = 0, rv = 0, wv = 0;
   logic e_req, e_gmiss, e_gspur, e_cmd, e_clash, e_addr, e_rdat, e_wdat;

   bus_proto_monitor uut (
      .clk(clk), .rst_n(rst_n), .bus_req(b), .bus_gnt(g), .cmd_rd(r), .cmd_wr(w),
      .addr_ok(a), .rdata_ok(rv), .wdata_ok(wv),
      .err_req_width(e_req), .err_gnt_missing(e_gmiss), .err_gnt_spurious(e_gspur),
      .err_cmd_ungranted(e_cmd), .err_cmd_clash(e_clash), .err_addr_phase(e_addr),
      .err_rdata_phase(e_rdat), .err_wdata_phase(e_wdat)
   );

   wire [7:0] errs = {e_wdat, e_rdat, e_addr, e_clash, e_cmd, e_gspur, e_gmiss, e_req};

   int checks = 0, fails = 0;
   logic [7:0] exp_err = '0;
   logic pb = 0, pg = 0, pr = 0, pw = 0, armed = 0;
   bit done = 0;

   function automatic string tag(int i);
      case (i)
         0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
         4: return "R5";  5: return "R6";  6: return "R7";  default: return "R8";
      endcase
   endfunction

   function automatic logic [7:0] rule_viol(logic cb, logic cg, logic cr, logic cw,
                                            logic ca, logic crv, logic cwv);
      logic [7:0] v;
      v[0] = cb && pb;
      v[1] = pb && !cg;
      v[2] = !pb && cg;
      v[3] = (cr || cw) && !pg;
      v[4] = cr && cw;
      v[5] = ca != (pr || pw);
      v[6] = crv != pr;
      v[7] = cwv != pw;
      return v;
   endfunction

   task automatic compare(string ctx);
      for (int i = 0; i < 8; i++) begin
         checks++;
         if (errs[i] !== exp_err[i]) begin
            fails++;
            $display("FAIL %s [%s] flag %0d actual=%b expected=%b at %0t",
                     tag(i), ctx, i, errs[i], exp_err[i], $time);
         end
      end
   endtask

   // drive one bus cycle, model the edge that samples it, compare (R12)
   task automatic cycle(logic cb, logic cg, logic cr, logic cw,
                        logic ca, logic crv, logic cwv, string ctx);
      b = cb; g = cg; r = cr; w = cw; a = ca; rv = crv; wv = cwv;
      @(posedge clk);
      if (armed) exp_err = exp_err | rule_viol(cb, cg, cr, cw, ca, crv, cwv);
      pb = cb; pg = cg; pr = cr; pw = cw; armed = 1;
      @(negedge clk);
      compare(ctx);
   endtask

   task automatic do_reset();
      rst_n = 0; b = 0; g = 0; r = 0; w = 0; a = 0; rv = 0; wv = 0;
      exp_err = '0; pb = 0; pg = 0; pr = 0; pw = 0; armed = 0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      compare("R11 in reset");
      rst_n = 1;
   endtask

   task automatic idle_hold(int n);
      for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0, 0, 0, "R9 hold");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();
      cycle(0, 0, 0, 0, 0, 0, 0, "R11 after reset");
      // legal read then write transaction
      cycle(1, 0, 0, 0, 0, 0, 0, "legal");
      cycle(0, 1, 0, 0, 0, 0, 0, "legal");
      cycle(0, 0, 1, 0, 0, 0, 0, "legal");
      cycle(1, 0, 0, 0, 1, 1, 0, "legal");
      cycle(0, 1, 0, 0, 0, 0, 0, "legal");
      cycle(0, 0, 0, 1, 0, 0, 0, "legal");
      cycle(0, 0, 0, 0, 1, 0, 1, "legal");
      idle_hold(2);
      // first cycle after reset masked
      do_reset();
      cycle(0, 1, 1, 1, 1, 1, 1, "R10 masked");
      cycle(0, 0, 0, 0, 1, 1, 1, "R10 follow");
      idle_hold(2);
      // R1
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R1");
      cycle(1, 0, 0, 0, 0, 0, 0, "R1"); cycle(1, 1, 0, 0, 0, 0, 0, "R1");
      cycle(0, 1, 0, 0, 0, 0, 0, "R1"); idle_hold(3);
      // R2
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R2");
      cycle(1, 0, 0, 0, 0, 0, 0, "R2"); cycle(0, 0, 0, 0, 0, 0, 0, "R2"); idle_hold(3);
      // R3
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R3");
      cycle(0, 1, 0, 0, 0, 0, 0, "R3"); idle_hold(3);
      // R4: command two cycles after grant
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R4");
      cycle(1, 0, 0, 0, 0, 0, 0, "R4"); cycle(0, 1, 0, 0, 0, 0, 0, "R4");
      cycle(0, 0, 0, 0, 0, 0, 0, "R4"); cycle(0, 0, 1, 0, 0, 0, 0, "R4");
      cycle(0, 0, 0, 0, 1, 1, 0, "R4"); idle_hold(3);
      // R5
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R5");
      cycle(1, 0, 0, 0, 0, 0, 0, "R5"); cycle(0, 1, 0, 0, 0, 0, 0, "R5");
      cycle(0, 0, 1, 1, 0, 0, 0, "R5"); cycle(0, 0, 0, 0, 1, 1, 1, "R5"); idle_hold(3);
      // R6 address missing
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R6");
      cycle(1, 0, 0, 0, 0, 0, 0, "R6"); cycle(0, 1, 0, 0, 0, 0, 0, "R6");
      cycle(0, 0, 1, 0, 0, 0, 0, "R6"); cycle(0, 0, 0, 0, 0, 1, 0, "R6"); idle_hold(3);
      // R7 read data missing
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R7");
      cycle(1, 0, 0, 0, 0, 0, 0, "R7"); cycle(0, 1, 0, 0, 0, 0, 0, "R7");
      cycle(0, 0, 1, 0, 0, 0, 0, "R7"); cycle(0, 0, 0, 0, 1, 0, 0, "R7"); idle_hold(3);
      // R8 write data missing, then stray
      do_reset(); cycle(0, 0, 0, 0, 0, 0, 0, "R8");
      cycle(1, 0, 0, 0, 0, 0, 0, "R8"); cycle(0, 1, 0, 0, 0, 0, 0, "R8");
      cycle(0, 0, 0, 1, 0, 0, 0, "R8"); cycle(0, 0, 0, 0, 1, 0, 0, "R8");
      cycle(0, 0, 0, 0, 0, 0, 1, "R8"); idle_hold(3);
      // random legal traffic with occasional corruption
      for (int seg = 0; seg < 6; seg++) begin
         do_reset();
         for (int k = 0; k < 400; k++) begin
            logic [6:0] s;
            logic nb, nr, nw;
            int pick;
            nb = !pb && ($urandom % 3 == 0);
            pick = int'($urandom % 3);
            nr = pg && (pick == 1);
            nw = pg && (pick == 2);
            s = {nb, pb, nr, nw, pr || pw, pr, pw};
            if ($urandom % 50 == 0) s[$urandom % 7] ^= 1'b1;
            cycle(s[6], s[5], s[4], s[3], s[2], s[1], s[0], "random");
         end
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule